// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block collects up to 32 interrupt sources into one cause register and drives a single interrupt line. Each source owns one bit index, and that index is the same in every register of the bank. A source pulse from hardware latches its cause bit. Software can also raise a cause by writing a one to a write-only set word.

A mask register hides causes from the interrupt line. Software can write the mask whole, or it can set and clear single bits through two alias words, so no read-modify-write is needed.

A per-bit control word picks how each cause bit is cleared. A bit at 0 selects write-one-to-clear. A bit at 1 selects clear-on-read, which clears the bit when a read returns it. The masked-cause word shows only unmasked causes and follows the same clearing rules. Reads are combinational on a simple register port: enable, write strobe, byte address, write data and read data.

Top module: `icm_bank`

## Requirements
- R1: After reset, the control word and the cause word read 0. The mask reads all ones, the masked view reads 0, and `irq_o` is low.
- R2: Word offsets are: 0x00 control, 0x04 cause, 0x08 masked cause, 0x0C cause-set, 0x10 mask, 0x14 mask-set, 0x18 mask-clear. The cause-set word reads 0. Mask-set and mask-clear read back the mask. Any other offset reads 0, and writes to it change nothing.
- R3: A high level on `hw_evt_i[n]` at a clock edge sets cause bit n at that edge.
- R4: Writing a one to bit n of the cause-set word sets cause bit n.
- R5: Writing a one to bit n of the cause word or of the masked-cause word clears cause bit n when control bit n is 0. When control bit n is 1, such a write leaves the bit unchanged.
- R6: A read of the cause word returns the cause and clears every returned one whose control bit is 1. A read of the masked-cause word clears only the unmasked ones in clear-on-read mode. A read never clears bits whose control bit is 0.
- R7: When a set (event or set word) and a clear (write or read) hit the same cause bit in one cycle, the bit ends set.
- R8: A write to the mask word loads it. A one written to mask-set sets that mask bit, and a one written to mask-clear clears it. Zero bits written to either alias leave the mask unchanged.
- R9: The masked-cause word reads as cause AND NOT mask.
- R10: `irq_o` is the OR of all masked-cause bits, registered. It changes one clock after the cause or mask changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| hw_evt_i | input | WIDTH | Hardware source events, one per bit |
| reg_en_i | input | 1 | Register access enable |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | ADDR_W | Byte address of the word |
| reg_wdata_i | input | WIDTH | Write data |
| reg_rdata_o | output | WIDTH | Read data, valid in the cycle of the read |
| irq_o | output | 1 | Interrupt request |

## Verification
The clearing logic is tried with mixed control words, where some bits are write-one-to-clear and others are clear-on-read. One write or read to the cause word must then clear exactly one group and leave the other, which separates the two modes bit by bit.

Reads of the masked view with part of the causes masked show that clear-on-read spares the hidden bits. Events that arrive in the same cycle as a clearing write or read show whether a set is lost.

Mask words with scattered bit patterns pass through the load, set-alias and clear-alias words, which exposes a mixed-up alias. The interrupt line is sampled just before and just after its register edge, which pins its one-cycle lag.

// File: rtl/icm_pkg.sv
`timescale 1ns/1ps
package icm_pkg;

  // Word index inside the bank; the order is the address map.
  typedef enum logic [2:0] {
    SEL_CTRL   = 3'd0,
    SEL_CAUSE  = 3'd1,
    SEL_MASKED = 3'd2,
    SEL_SET    = 3'd3,
    SEL_MASK   = 3'd4,
    SEL_MSET   = 3'd5,
    SEL_MCLR   = 3'd6,
    SEL_NONE   = 3'd7
  } icm_sel_e;

  typedef struct packed {
    logic wr_ctrl;
    logic wr_clr;
    logic wr_set;
    logic wr_mask;
    logic wr_mset;
    logic wr_mclr;
    logic rd_cause;
    logic rd_masked;
  } icm_strb_t;

  localparam int unsigned NUM_WORDS = 7;

endpackage

// File: rtl/icm_rst_sync.sv
`timescale 1ns/1ps
module icm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/icm_decode.sv
`timescale 1ns/1ps
module icm_decode
  import icm_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output icm_sel_e          sel_o,
  output icm_strb_t         strb_o
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             hit;
  logic             wr;
  logic             rd;

  always_comb begin
    idx   = addr_i[ADDR_W-1:2];
    hit   = (addr_i[1:0] == 2'b00) && (idx < IDX_W'(NUM_WORDS));
    sel_o = hit ? icm_sel_e'(idx[2:0]) : SEL_NONE;
    wr    = en_i & we_i;
    rd    = en_i & ~we_i;

    strb_o           = '0;
    strb_o.wr_ctrl   = wr && (sel_o == SEL_CTRL);
    strb_o.wr_clr    = wr && ((sel_o == SEL_CAUSE) || (sel_o == SEL_MASKED));
    strb_o.wr_set    = wr && (sel_o == SEL_SET);
    strb_o.wr_mask   = wr && (sel_o == SEL_MASK);
    strb_o.wr_mset   = wr && (sel_o == SEL_MSET);
    strb_o.wr_mclr   = wr && (sel_o == SEL_MCLR);
    strb_o.rd_cause  = rd && (sel_o == SEL_CAUSE);
    strb_o.rd_masked = rd && (sel_o == SEL_MASKED);
  end

endmodule

// File: rtl/icm_cause_bit.sv
`timescale 1ns/1ps
module icm_cause_bit (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic evt_i,
  input  logic wd_i,
  input  logic ctrl_we_i,
  input  logic clr_we_i,
  input  logic set_we_i,
  input  logic rd_cause_i,
  input  logic rd_masked_i,
  input  logic mask_i,
  output logic cause_o,
  output logic ctrl_o
);

  logic ctrl_q;
  logic cause_q;
  logic cause_d;
  logic cause_en;
  logic set_req;
  logic w1c_req;
  logic cor_req;

  always_comb begin
    set_req  = evt_i | (set_we_i & wd_i);
    w1c_req  = clr_we_i & wd_i & ~ctrl_q;
    cor_req  = ctrl_q & cause_q & (rd_cause_i | (rd_masked_i & ~mask_i));
    cause_en = set_req | w1c_req | cor_req;
    // a set in the same cycle as a clear must not be lost
    cause_d  = set_req;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ctrl_q <= 1'b0;
    end else if (ctrl_we_i) begin
      ctrl_q <= wd_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cause_q <= 1'b0;
    end else if (cause_en) begin
      cause_q <= cause_d;
    end
  end

  assign cause_o = cause_q;
  assign ctrl_o  = ctrl_q;

endmodule

// File: rtl/icm_mask_reg.sv
`timescale 1ns/1ps
module icm_mask_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             load_i,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [WIDTH-1:0] wd_i,
  output logic [WIDTH-1:0] mask_o
);

  logic [WIDTH-1:0] mask_q;
  logic [WIDTH-1:0] mask_d;
  logic             mask_en;

  always_comb begin
    mask_en = load_i | set_i | clr_i;
    mask_d  = mask_q;
    if (load_i) begin
      mask_d = wd_i;
    end else if (set_i) begin
      mask_d = mask_q | wd_i;
    end else if (clr_i) begin
      mask_d = mask_q & ~wd_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      mask_q <= '1;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  assign mask_o = mask_q;

endmodule

// File: rtl/icm_bank.sv
`timescale 1ns/1ps
module icm_bank
  import icm_pkg::*;
#(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic [WIDTH-1:0]  hw_evt_i,
  input  logic              reg_en_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [WIDTH-1:0]  reg_wdata_i,
  output logic [WIDTH-1:0]  reg_rdata_o,
  output logic              irq_o
);

  logic             rst_n_q;
  icm_sel_e         sel;
  icm_strb_t        strb;
  logic [WIDTH-1:0] cause_q;
  logic [WIDTH-1:0] ctrl_q;
  logic [WIDTH-1:0] mask_q;
  logic [WIDTH-1:0] masked;
  logic             irq_q;
  logic             irq_d;

  icm_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_n_q)
  );

  icm_decode #(.ADDR_W(ADDR_W)) u_decode (
    .en_i   (reg_en_i),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .sel_o  (sel),
    .strb_o (strb)
  );

  icm_mask_reg #(.WIDTH(WIDTH)) u_mask (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_q),
    .load_i  (strb.wr_mask),
    .set_i   (strb.wr_mset),
    .clr_i   (strb.wr_mclr),
    .wd_i    (reg_wdata_i),
    .mask_o  (mask_q)
  );

  for (genvar b = 0; b < WIDTH; b++) begin : g_src
    icm_cause_bit u_bit (
      .clk_i       (clk_i),
      .rst_n_i     (rst_n_q),
      .evt_i       (hw_evt_i[b]),
      .wd_i        (reg_wdata_i[b]),
      .ctrl_we_i   (strb.wr_ctrl),
      .clr_we_i    (strb.wr_clr),
      .set_we_i    (strb.wr_set),
      .rd_cause_i  (strb.rd_cause),
      .rd_masked_i (strb.rd_masked),
      .mask_i      (mask_q[b]),
      .cause_o     (cause_q[b]),
      .ctrl_o      (ctrl_q[b])
    );
  end

  always_comb begin
    masked = cause_q & ~mask_q;
    irq_d  = |masked;
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_en_i && !reg_we_i) begin
      unique case (sel)
        SEL_CTRL:   reg_rdata_o = ctrl_q;
        SEL_CAUSE:  reg_rdata_o = cause_q;
        SEL_MASKED: reg_rdata_o = masked;
        SEL_MASK,
        SEL_MSET,
        SEL_MCLR:   reg_rdata_o = mask_q;
        default:    reg_rdata_o = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_q) begin
    if (!rst_n_q) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/icm_bank_chk.sv
`timescale 1ns/1ps
module icm_bank_chk #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic [WIDTH-1:0]  hw_evt,
  input logic              en,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [WIDTH-1:0]  wdata,
  input logic [WIDTH-1:0]  rdata,
  input logic [WIDTH-1:0]  cause,
  input logic [WIDTH-1:0]  ctrl,
  input logic [WIDTH-1:0]  mask,
  input logic              irq
);

  logic             set_wr;
  logic             clr_wr;
  logic             cause_rd;
  logic             setw_rd;
  logic             mset_wr;
  logic             mclr_wr;
  logic [WIDTH-1:0] set_bits;

  always_comb begin
    set_wr   = en & we  & (addr == ADDR_W'(12));
    clr_wr   = en & we  & (addr == ADDR_W'(4));
    cause_rd = en & ~we & (addr == ADDR_W'(4));
    setw_rd  = en & ~we & (addr == ADDR_W'(12));
    mset_wr  = en & we  & (addr == ADDR_W'(20));
    mclr_wr  = en & we  & (addr == ADDR_W'(24));
    set_bits = set_wr ? wdata : '0;
  end

  AST_SET_WORD_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n)
    setw_rd |-> (rdata == '0)); // R2

  AST_EVT_SETS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (|hw_evt) |=> ((cause & $past(hw_evt)) == $past(hw_evt))); // R3

  AST_SW_SET_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_n)
    set_wr |=> ((cause & $past(wdata)) == $past(wdata))); // R4

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_n)
    1'b1 |=> ((cause & ~$past(cause) & ~$past(hw_evt) & ~$past(set_bits)) == '0)); // R4

  AST_COR_CLEARS_RETURNED: assert property (@(posedge clk_i) disable iff (!rst_n)
    cause_rd |=> ((cause & $past(cause & ctrl) & ~$past(hw_evt)) == '0)); // R6

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_n)
    (clr_wr && |(hw_evt & wdata)) |=>
      ((cause & $past(hw_evt & wdata)) == $past(hw_evt & wdata))); // R7

  AST_MASK_SET_ALIAS: assert property (@(posedge clk_i) disable iff (!rst_n)
    mset_wr |=> ((mask & $past(wdata)) == $past(wdata))); // R8

  AST_MASK_CLR_ALIAS: assert property (@(posedge clk_i) disable iff (!rst_n)
    mclr_wr |=> ((mask & $past(wdata)) == '0)); // R8

  AST_IRQ_LAGS_ONE: assert property (@(posedge clk_i) disable iff (!rst_n)
    1'b1 |=> (irq == |($past(cause) & ~$past(mask)))); // R10

endmodule

bind icm_bank icm_bank_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_icm_bank_chk (
  .clk_i  (clk_i),
  .rst_n  (rst_n_q),
  .hw_evt (hw_evt_i),
  .en     (reg_en_i),
  .we     (reg_we_i),
  .addr   (reg_addr_i),
  .wdata  (reg_wdata_i),
  .rdata  (reg_rdata_o),
  .cause  (cause_q),
  .ctrl   (ctrl_q),
  .mask   (mask_q),
  .irq    (irq_o)
);

// File: tb/test_icm_bank.sv
`timescale 1ns/1ps
module test_icm_bank;

  localparam int unsigned WIDTH  = 32;
  localparam int unsigned ADDR_W = 5;

  logic              clk;
  logic              rst_n;
  logic [WIDTH-1:0]  hw_evt;
  logic              en;
  logic              we;
  logic [ADDR_W-1:0] addr;
  logic [WIDTH-1:0]  wdata;
  logic [WIDTH-1:0]  rdata;
  logic              irq;

  int n_checks;
  int n_fails;
  bit done;

  icm_bank #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) i_icm_bank (
    .clk_i       (clk),
    .rst_n_i     (rst_n),
    .hw_evt_i    (hw_evt),
    .reg_en_i    (en),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [WIDTH-1:0] act,
                       input logic [WIDTH-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [WIDTH-1:0] d);
    @(negedge clk);
    en = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    en = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [WIDTH-1:0] d);
    @(negedge clk);
    en = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    en = 1'b0;
  endtask

  task automatic clean();
    bus_wr(5'h00, '0);
    bus_wr(5'h04, '1);
    bus_wr(5'h10, '1);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [WIDTH-1:0] v;
    check("R1 irq", {31'd0, irq}, '0);
    bus_rd(5'h00, v); check("R1 ctrl", v, '0);
    bus_rd(5'h04, v); check("R1 cause", v, '0);
    bus_rd(5'h08, v); check("R1 masked", v, '0);
    bus_rd(5'h10, v); check("R1 mask", v, '1);
  endtask

  task automatic t_map();
    logic [WIDTH-1:0] v;
    clean();
    bus_wr(5'h1C, 32'hFFFF_FFFF);
    bus_rd(5'h1C, v); check("R2 unused offset reads 0", v, '0);
    bus_rd(5'h04, v); check("R2 unused write leaves cause", v, '0);
    bus_rd(5'h00, v); check("R2 unused write leaves ctrl", v, '0);
    bus_rd(5'h10, v); check("R2 unused write leaves mask", v, '1);
    bus_wr(5'h0C, 32'h0000_0100);
    bus_rd(5'h0C, v); check("R2 set word reads 0", v, '0);
    bus_wr(5'h10, 32'h00AB_CD00);
    bus_rd(5'h14, v); check("R2 mask-set reads mask", v, 32'h00AB_CD00);
    bus_rd(5'h18, v); check("R2 mask-clear reads mask", v, 32'h00AB_CD00);
  endtask

  task automatic t_hw_evt();
    logic [WIDTH-1:0] v;
    clean();
    @(negedge clk);
    hw_evt = 32'h8000_0001;
    @(negedge clk);
    hw_evt = '0;
    bus_rd(5'h04, v); check("R3 event latches cause", v, 32'h8000_0001);
  endtask

  task automatic t_sw_set();
    logic [WIDTH-1:0] v;
    clean();
    bus_wr(5'h0C, 32'h00F0_0000);
    bus_rd(5'h04, v); check("R4 set word sets cause", v, 32'h00F0_0000);
  endtask

  task automatic t_w1c();
    logic [WIDTH-1:0] v;
    clean();
    bus_wr(5'h00, 32'h0000_0F00);
    bus_wr(5'h0C, 32'h0000_0F0F);
    bus_wr(5'h04, 32'h0000_0FFF);
    bus_rd(5'h00, v); check("R5 ctrl readback", v, 32'h0000_0F00);
    bus_wr(5'h0C, 32'h0000_0005);
    bus_wr(5'h08, 32'h0000_0001);
    bus_wr(5'h10, '0);
    bus_rd(5'h04, v); check("R5 write-one clears only w1c bits", v, 32'h0000_0F04);
    bus_rd(5'h04, v); check("R6 read spares w1c bits", v, 32'h0000_0004);
  endtask

  task automatic t_cor();
    logic [WIDTH-1:0] v;
    clean();
    bus_wr(5'h00, 32'h0000_00F0);
    bus_wr(5'h0C, 32'h0000_00FF);
    bus_wr(5'h18, 32'h0000_0030);
    bus_rd(5'h08, v); check("R6 masked read value", v, 32'h0000_0030);
    bus_rd(5'h04, v); check("R6 masked read cleared unmasked cor", v, 32'h0000_00CF);
    bus_rd(5'h04, v); check("R6 cause read cleared cor bits", v, 32'h0000_000F);
  endtask

  task automatic t_collision();
    logic [WIDTH-1:0] v;
    clean();
    bus_wr(5'h0C, 32'h0000_0008);
    @(negedge clk);
    hw_evt = 32'h0000_0008;
    en = 1'b1; we = 1'b1; addr = 5'h04; wdata = 32'h0000_0008;
    @(negedge clk);
    hw_evt = '0; en = 1'b0; we = 1'b0; wdata = '0;
    bus_rd(5'h04, v); check("R7 event beats w1c write", v, 32'h0000_0008);
    bus_wr(5'h00, 32'h0000_0008);
    @(negedge clk);
    hw_evt = 32'h0000_0008;
    en = 1'b1; we = 1'b0; addr = 5'h04;
    #1 v = rdata;
    @(negedge clk);
    hw_evt = '0; en = 1'b0;
    check("R7 cor read returns bit", v, 32'h0000_0008);
    bus_rd(5'h04, v); check("R7 event beats cor read", v, 32'h0000_0008);
    bus_rd(5'h04, v); check("R6 later read clears", v, '0);
  endtask

  task automatic t_mask();
    logic [WIDTH-1:0] v;
    clean();
    bus_wr(5'h10, 32'h1234_5678);
    bus_rd(5'h10, v); check("R8 mask load", v, 32'h1234_5678);
    bus_wr(5'h14, 32'h0000_000F);
    bus_rd(5'h10, v); check("R8 mask-set alias", v, 32'h1234_567F);
    bus_wr(5'h18, 32'h1200_0000);
    bus_rd(5'h10, v); check("R8 mask-clear alias", v, 32'h0034_567F);
    bus_wr(5'h0C, 32'h0000_FFFF);
    bus_rd(5'h08, v); check("R9 masked view", v, 32'h0000_A980);
  endtask

  task automatic t_irq();
    clean();
    bus_wr(5'h0C, 32'h0000_0001);
    @(negedge clk);
    check("R10 masked cause keeps irq low", {31'd0, irq}, '0);
    bus_wr(5'h18, 32'h0000_0001);
    check("R10 irq not yet high", {31'd0, irq}, '0);
    @(negedge clk);
    check("R10 irq high one cycle later", {31'd0, irq}, 32'd1);
    bus_wr(5'h04, 32'h0000_0001);
    check("R10 irq not yet low", {31'd0, irq}, 32'd1);
    @(negedge clk);
    check("R10 irq low one cycle later", {31'd0, irq}, '0);
  endtask

  initial begin
    n_checks = 0; n_fails = 0; done = 1'b0;
    rst_n = 1'b0; hw_evt = '0; en = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_map();
    t_hw_evt();
    t_sw_set();
    t_w1c();
    t_cor();
    t_collision();
    t_mask();
    t_irq();
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule